// File: doc/BRIEF.md
# Maxima-Based Defuzzifier with Selectable Method

This block turns an aggregated fuzzy output set into one crisp 8-bit value. The set arrives as sixteen membership degrees, one for each point of an evenly spaced output universe, where point `i` stands for the crisp value `i*17`, so the points run from 0 to 255. The block finds the peak degree and the set of points that reach it. It then reports one of three values. The lowest such point is one choice, the highest is another, and the truncated average of their indices is the third.

A 2-bit method select travels with each input vector. The method can therefore change from one vector to the next while the pipeline keeps accepting a vector every cycle, and a result already in flight is never affected. The block has two register stages. The first stage searches for the peak and tracks the indices. The second stage selects the method, divides for the mean, and scales the index onto the output range.

Top module: `maxima_defuzzifier`

## Requirements
- R1: With `method` = 2'b01, the result is 17 times the lowest index whose degree equals the maximum degree of the vector.
- R2: With `method` = 2'b10, the result is 17 times the highest index whose degree equals the maximum degree of the vector.
- R3: With `method` = 2'b00 or 2'b11, the result is 17 times floor(sum of all indices at the maximum degree / number of such indices).
- R4: When every degree of a vector is zero, the result is 0 in every method.
- R5: A vector sampled with `in_valid` high at rising edge k gives `out_valid` high and its result on `out_value` after rising edge k+1. `out_valid` is low in every other cycle.
- R6: The method is sampled together with its vector. Back-to-back vectors that carry different methods each give the result of their own method.
- R7: After a synchronous reset with `rst_n` low, `out_valid` and `out_value` are both 0.
- R8: Degree `i` occupies bits [8i+7:8i] of `degrees` and is compared as an unsigned number.
- R9: While no result is delivered, `out_value` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `degrees` and `method` |
| degrees | input | 128 | Sixteen packed 8-bit membership degrees |
| method | input | 2 | 00/11 mean, 01 smallest, 10 largest of maxima |
| out_valid | output | 1 | Result on `out_value` is new this cycle |
| out_value | output | 8 | Crisp output value |

## Verification
Two things can happen in the same cycle. The first stage can take in a new vector with one method while the second stage finishes the previous vector under a different method. The bench provokes this by streaming vectors on consecutive cycles, switching the method at each step and using tie patterns where the three methods give different answers. Each result that comes out is compared with a model of the method that entered with its vector. A mix-up between the method in flight and the method being sampled then shows up as a wrong value.

// File: rtl/defz_pkg.sv
// Package: shared method encoding for the maxima-based defuzzifier.
// Assumes the two-bit select is the only method input of the block.
package defz_pkg;
    typedef enum logic [1:0] {
        DZ_MEAN     = 2'b00,
        DZ_SMALLEST = 2'b01,
        DZ_LARGEST  = 2'b10,
        DZ_MEAN_ALT = 2'b11
    } dz_method_e;
endpackage

// File: rtl/defz_peak_scan.sv
// Stage 1: finds the peak degree and the lowest index, highest index,
// index sum and count of all points that reach it. Registers these
// together with the method so a later method change cannot touch them.
// Assumes degree i sits at bits [i*DEG_W +: DEG_W] of deg_vec.
module defz_peak_scan
    import defz_pkg::*;
#(
    parameter int N_PTS = 16,
    parameter int DEG_W = 8,
    localparam int IDX_W = $clog2(N_PTS),
    localparam int CNT_W = $clog2(N_PTS + 1),
    localparam int SUM_W = $clog2(N_PTS * (N_PTS - 1) / 2 + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [N_PTS*DEG_W-1:0] deg_vec,
    input  dz_method_e             method,
    output logic                   s1_valid,
    output dz_method_e             s1_method,
    output logic                   s1_zero,
    output logic [IDX_W-1:0]       s1_first,
    output logic [IDX_W-1:0]       s1_last,
    output logic [SUM_W-1:0]       s1_sum,
    output logic [CNT_W-1:0]       s1_cnt
);
    logic [DEG_W-1:0] deg_arr [N_PTS];
    logic [N_PTS-1:0] at_peak;
    logic [DEG_W-1:0] peak;
    logic [IDX_W-1:0] first_c, last_c;
    logic [SUM_W-1:0] sum_c;
    logic [CNT_W-1:0] cnt_c;

    // Unpack the flat degree vector into one entry per universe point.
    genvar g;
    generate
        for (g = 0; g < N_PTS; g++) begin : g_unpack
            assign deg_arr[g] = deg_vec[g*DEG_W +: DEG_W];
            assign at_peak[g] = (deg_arr[g] == peak);
        end
    endgenerate

    // Unsigned maximum over all degrees.
    always_comb begin
        peak = '0;
        for (int i = 0; i < N_PTS; i++)
            if (deg_arr[i] > peak) peak = deg_arr[i];
    end

    // Lowest and highest index of the peak set.
    always_comb begin
        first_c = '0;
        last_c  = '0;
        for (int i = N_PTS - 1; i >= 0; i--)
            if (at_peak[i]) first_c = IDX_W'(i);
        for (int i = 0; i < N_PTS; i++)
            if (at_peak[i]) last_c = IDX_W'(i);
    end

    // Index sum and member count of the peak set, for the mean.
    always_comb begin
        sum_c = '0;
        cnt_c = '0;
        for (int i = 0; i < N_PTS; i++)
            if (at_peak[i]) begin
                sum_c = sum_c + SUM_W'(i);
                cnt_c = cnt_c + CNT_W'(1);
            end
    end

    // Stage register; the data fields load only with a valid vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_method <= DZ_MEAN;
            s1_zero   <= 1'b1;
            s1_first  <= '0;
            s1_last   <= '0;
            s1_sum    <= '0;
            s1_cnt    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_method <= method;
                s1_zero   <= (peak == '0);
                s1_first  <= first_c;
                s1_last   <= last_c;
                s1_sum    <= sum_c;
                s1_cnt    <= cnt_c;
            end
        end
    end

    // A stage-1 entry exists only if a vector was offered one edge earlier.
    assert_s1_from_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(in_valid));
    // The peak set is never empty.
    assert_peak_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> s1_cnt != '0);
    // Lowest index of the peak set never exceeds the highest.
    assert_first_le_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> s1_first <= s1_last);
    // The count cannot exceed the span between the lowest and highest index.
    assert_count_in_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> 32'(s1_cnt) <= 32'(s1_last) - 32'(s1_first) + 1);
endmodule

// File: rtl/defz_div.sv
// Combinational restoring divider: quo = floor(num / den).
// Assumes den is nonzero whenever the quotient is used.
module defz_div #(
    parameter int NUM_W = 7,
    parameter int DEN_W = 5
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo
);
    logic [DEN_W:0] rem;

    // Shift-subtract long division, one quotient bit per numerator bit.
    always_comb begin
        rem = '0;
        quo = '0;
        for (int b = NUM_W - 1; b >= 0; b--) begin
            rem = {rem[DEN_W-1:0], num[b]};
            if (rem >= {1'b0, den}) begin
                rem    = rem - {1'b0, den};
                quo[b] = 1'b1;
            end
        end
    end

    // The quotient satisfies q*d <= n < (q+1)*d.
    always_comb begin
        if (den != '0)
            assert_div_exact_R3: assert (32'(quo) * 32'(den) <= 32'(num) &&
                                         32'(num) < (32'(quo) + 1) * 32'(den));
    end
endmodule

// File: rtl/defz_select.sv
// Stage 2: picks the index for the registered method, divides for the
// mean, forces zero for an all-zero set, scales onto the output range.
// Assumes OUT_W-bit full scale divides evenly over N_PTS-1 steps.
module defz_select
    import defz_pkg::*;
#(
    parameter int N_PTS = 16,
    parameter int OUT_W = 8,
    localparam int IDX_W = $clog2(N_PTS),
    localparam int CNT_W = $clog2(N_PTS + 1),
    localparam int SUM_W = $clog2(N_PTS * (N_PTS - 1) / 2 + 1),
    localparam int STEP  = ((1 << OUT_W) - 1) / (N_PTS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  dz_method_e       s1_method,
    input  logic             s1_zero,
    input  logic [IDX_W-1:0] s1_first,
    input  logic [IDX_W-1:0] s1_last,
    input  logic [SUM_W-1:0] s1_sum,
    input  logic [CNT_W-1:0] s1_cnt,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value
);
    logic [SUM_W-1:0]       mean_q;
    logic [IDX_W-1:0]       pick;
    logic [IDX_W+OUT_W-1:0] scaled;

    defz_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
        .num (s1_sum),
        .den (s1_cnt),
        .quo (mean_q)
    );

    // Choose the universe index from the method registered with the data.
    always_comb begin
        unique case (s1_method)
            DZ_SMALLEST: pick = s1_first;
            DZ_LARGEST:  pick = s1_last;
            default:     pick = IDX_W'(mean_q);
        endcase
        if (s1_zero) pick = '0;
        scaled = (IDX_W + OUT_W)'(pick) * (IDX_W + OUT_W)'(STEP);
    end

    // Output register; the value holds between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_value <= OUT_W'(scaled);
        end
    end

    // A result appears only one edge after a stage-1 entry.
    assert_out_from_s1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));
    // Without a stage-1 entry the output value does not move.
    assert_value_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_value));
    // Every result lies on a universe point.
    assert_on_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_value) % STEP) == 0);
    // An all-zero set gives zero.
    assert_zero_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && s1_zero |=> out_value == '0);
endmodule

// File: rtl/maxima_defuzzifier.sv
// Top: two-stage maxima-based defuzzifier with a per-vector method select.
// Assumes a new vector may arrive every cycle; there is no back-pressure.
module maxima_defuzzifier
    import defz_pkg::*;
#(
    parameter int N_PTS = 16,
    parameter int DEG_W = 8,
    parameter int OUT_W = 8,
    localparam int IDX_W = $clog2(N_PTS),
    localparam int CNT_W = $clog2(N_PTS + 1),
    localparam int SUM_W = $clog2(N_PTS * (N_PTS - 1) / 2 + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [N_PTS*DEG_W-1:0] degrees,
    input  logic [1:0]             method,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_value
);
    logic             s1_valid;
    dz_method_e       s1_method;
    logic             s1_zero;
    logic [IDX_W-1:0] s1_first, s1_last;
    logic [SUM_W-1:0] s1_sum;
    logic [CNT_W-1:0] s1_cnt;

    defz_peak_scan #(.N_PTS(N_PTS), .DEG_W(DEG_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .deg_vec   (degrees),
        .method    (dz_method_e'(method)),
        .s1_valid  (s1_valid),
        .s1_method (s1_method),
        .s1_zero   (s1_zero),
        .s1_first  (s1_first),
        .s1_last   (s1_last),
        .s1_sum    (s1_sum),
        .s1_cnt    (s1_cnt)
    );

    defz_select #(.N_PTS(N_PTS), .OUT_W(OUT_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_method (s1_method),
        .s1_zero   (s1_zero),
        .s1_first  (s1_first),
        .s1_last   (s1_last),
        .s1_sum    (s1_sum),
        .s1_cnt    (s1_cnt),
        .out_valid (out_valid),
        .out_value (out_value)
    );

    // A result is delivered exactly two edges after its vector was sampled.
    assert_latency_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid) && $past(in_valid, 2));
endmodule

// File: tb/sim_maxima_defuzzifier.sv
module sim_maxima_defuzzifier;
    localparam int NP = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] degrees = '0;
    logic [1:0]   method = 2'b00;
    logic         out_valid;
    logic [7:0]   out_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    maxima_defuzzifier u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .degrees(degrees),
        .method(method), .out_valid(out_valid), .out_value(out_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference from the requirements: degree i at bits [8i+7:8i], unsigned.
    function automatic int model(input logic [127:0] v, input logic [1:0] m);
        int pk = 0, lo = -1, hi = 0, s = 0, n = 0;
        for (int i = 0; i < NP; i++) if (int'(v[8*i +: 8]) > pk) pk = int'(v[8*i +: 8]);
        if (pk == 0) return 0;
        for (int i = 0; i < NP; i++)
            if (int'(v[8*i +: 8]) == pk) begin
                if (lo < 0) lo = i;
                hi = i; s += i; n++;
            end
        case (m)
            2'b01:   return 17 * lo;
            2'b10:   return 17 * hi;
            default: return 17 * (s / n);
        endcase
    endfunction

    function automatic logic [127:0] mk(input int idx_a, input int idx_b,
                                        input int idx_c, input int pk, input int base);
        logic [127:0] v;
        for (int i = 0; i < NP; i++) v[8*i +: 8] = 8'(base + (i % 3));
        if (idx_a >= 0) v[8*idx_a +: 8] = 8'(pk);
        if (idx_b >= 0) v[8*idx_b +: 8] = 8'(pk);
        if (idx_c >= 0) v[8*idx_c +: 8] = 8'(pk);
        return v;
    endfunction

    // One vector, one method; checks latency and value (R5 plus given req).
    task automatic run_one(input logic [127:0] v, input logic [1:0] m, input string req);
        @(negedge clk);
        degrees = v; method = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; method = ~m; degrees = ~v;
        check("R5 no early valid", int'(out_valid), 0);
        @(negedge clk);
        check("R5 valid", int'(out_valid), 1);
        check(req, int'(out_value), model(v, m));
    endtask

    task automatic t_reset();
        check("R7 valid", int'(out_valid), 0);
        check("R7 value", int'(out_value), 0);
    endtask

    task automatic t_methods();
        logic [127:0] pats [5];
        pats[0] = mk(5, -1, -1, 200, 10);
        pats[1] = mk(2, 9, 13, 250, 20);
        pats[2] = mk(0, 15, -1, 99, 0);
        pats[3] = mk(1, 2, -1, 77, 3);
        pats[4] = {16{8'd9}};
        for (int p = 0; p < 5; p++) begin
            run_one(pats[p], 2'b01, "R1 smallest");
            run_one(pats[p], 2'b10, "R2 largest");
            run_one(pats[p], 2'b00, "R3 mean");
            run_one(pats[p], 2'b11, "R3 mean alt");
        end
    endtask

    task automatic t_zero();
        for (int m = 0; m < 4; m++) run_one('0, 2'(m), "R4 all zero");
    endtask

    task automatic t_unsigned();
        logic [127:0] v = {16{8'h7F}};
        v[8*3 +: 8] = 8'h80;
        run_one(v, 2'b01, "R8 unsigned field");
        check("R8 value", int'(out_value), 51);
        run_one(v, 2'b10, "R8 unsigned field");
    endtask

    // Back-to-back vectors with a method switch on every cycle (R6).
    task automatic t_stream();
        logic [127:0] v [6];
        logic [1:0]   m [6];
        for (int k = 0; k < 6; k++) begin
            v[k] = mk(k % 4, 6 + k, 14 - (k % 2), 180 + k, k);
            m[k] = 2'(k + 1);
        end
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R6 stream valid", int'(out_valid), 1);
                check("R6 stream value", int'(out_value), model(v[c-2], m[c-2]));
            end
            if (c < 6) begin
                degrees = v[c]; method = m[c]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R5 idle valid", int'(out_valid), 0);
    endtask

    // Value holds while inputs toggle without valid (R9).
    task automatic t_hold();
        int last;
        run_one(mk(11, -1, -1, 240, 0), 2'b00, "R3 mean");
        last = int'(out_value);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            degrees = mk(c, -1, -1, 200, 1); method = 2'(c);
            check("R9 hold", int'(out_value), last);
            check("R5 idle valid", int'(out_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_methods();
        t_zero();
        t_unsigned();
        t_stream();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule